// File: doc/BRIEF.md
# Bus Enumeration Search Master

This block is the master-side controller that discovers the 64-bit registration numbers of devices sharing a single open-drain, wired-AND serial line. It does not produce any line timing. It drives an abstract slot layer through a request/done handshake. Each slot is a line reset with presence detect, a write of one bit, or a read of one bit. A start pulse runs one search pass, and the pass delivers exactly one registration number.

At every bit position a pass reads the bit value and then its complement from all devices that are still taking part, and it then writes the branch it selects. Devices whose bit differs from the written value drop out. When the two reads are both 0, the devices disagree at that position (a fork), and the master has to pick a branch. It picks from the fork position recorded on the previous pass and from the previous result. It records the deepest fork at which it chose 0, so the next pass can take the other branch there. Repeated passes therefore walk the whole tree. A flag marks the pass that found the final device. The pass after that one starts a new enumeration from the beginning.

A pass stops early in two cases. If no presence is seen after the line reset, a no-device flag is raised. If both reads return 1, no device answered, and a no-response flag is raised.

Top module: `bus_enum_master`

## Requirements
- R1: A start pulse while idle sets busy on the next cycle, and the first slot requested is a line reset (slot_op 0). A start pulse while busy has no effect on the slot sequence.
- R2: If the reset slot returns slot_rbit 0 (no presence), the pass ends with a one-cycle pass_done and no_device set, and no further slot is requested.
- R3: After a presence, the master issues eight write slots (slot_op 1) carrying the command byte F0h, least significant bit first: 0,0,0,0,1,1,1,1.
- R4: For positions 1 to 64, with position p standing for registration bit p-1, the master issues two read slots (slot_op 2) and then one write slot.
- R5: When the two reads differ, the write carries the value of the first read.
- R6: When both reads are 0, the write carries 1 if the position equals the stored fork position, 0 if the position is greater, and otherwise the bit the previous pass wrote at that position.
- R7: When both reads are 1, the pass ends after the second read with pass_done and no_response. No write slot follows.
- R8: After a complete pass, rom_id bit p-1 holds the value written at position p, and pass_done is high for exactly one cycle. last_found is high exactly when no fork took the 0 branch. rom_id stays unchanged while idle.
- R9: The fork position stored for the next pass is the highest position at which a fork took 0. After a pass with last_found or an error, the next start begins from no stored fork. Successive passes then return each device exactly once.
- R10: slot_req, slot_op and slot_wbit hold steady until slot_done. slot_req is low in the cycle after each accepted slot.
- R11: During and straight after reset, busy, pass_done, last_found, no_device, no_response and slot_req are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one search pass when idle |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-cycle pulse when a pass ends |
| rom_id | output | 64 | Registration number from the last complete pass |
| last_found | output | 1 | The last complete pass found the final device |
| no_device | output | 1 | The last pass saw no presence |
| no_response | output | 1 | The last pass read 1 in both read slots at one position |
| slot_req | output | 1 | Slot request to the slot layer |
| slot_op | output | 2 | 0 line reset, 1 write, 2 read |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_done | input | 1 | Slot layer finished the requested slot |
| slot_rbit | input | 1 | Presence (reset slot) or read value, valid with slot_done |

## Verification
The bench models a population of devices on a wired-AND line and predicts every written branch bit from its own search bookkeeping. It targets forks at the first and at the last position. A design that compared the fork position off by one, or that reused the wrong previous bit, would list the same device twice or skip one. It also checks that enumeration restarts after the final device and after a mid-pass loss of all devices. A design that kept a stale fork position there would return a device from the middle of the tree. A start pulse during a pass and a line with no devices cover the cases where a faulty design would restart a pass or keep issuing slots.

// File: rtl/bus_enum_pkg.sv
package bus_enum_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } slot_op_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRES = 3'd1,
        PH_CMD  = 3'd2,
        PH_RD_T = 3'd3,
        PH_RD_C = 3'd4,
        PH_WR   = 3'd5
    } phase_e;

endpackage

// File: rtl/enum_slot_gate.sv
module enum_slot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic done_i,
    output logic req_o
);
    logic gap_d, gap_q;

    always_comb begin
        req_o = want & ~gap_q;
        gap_d = req_o & done_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= gap_d;
    end

    // R10: a request stays up until the slot layer answers
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !done_i |=> req_o);

    // R10: one idle cycle after each accepted slot
    p_req_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && done_i |=> !req_o);

endmodule

// File: rtl/enum_branch_pick.sv
module enum_branch_pick #(
    parameter int POS_W = 7
) (
    input  logic             bit_t,
    input  logic             bit_c,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] last_fork,
    input  logic             prev_bit,
    output logic             dir,
    output logic             zero_fork,
    output logic             dead
);
    logic fork_here;

    always_comb begin
        fork_here = ~bit_t & ~bit_c;
        dead      = bit_t & bit_c;
        if (!fork_here)             dir = bit_t;
        else if (pos == last_fork)  dir = 1'b1;
        else if (pos > last_fork)   dir = 1'b0;
        else                        dir = prev_bit;
        zero_fork = fork_here & ~dir;
    end

endmodule

// File: rtl/bus_enum_master.sv
module bus_enum_master
    import bus_enum_pkg::*;
#(
    parameter int                ID_W     = 64,
    parameter int                CMD_W    = 8,
    parameter logic [CMD_W-1:0]  CMD_CODE = 8'hF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            pass_done,
    output logic [ID_W-1:0] rom_id,
    output logic            last_found,
    output logic            no_device,
    output logic            no_response,
    output logic            slot_req,
    output logic [1:0]      slot_op,
    output logic            slot_wbit,
    input  logic            slot_done,
    input  logic            slot_rbit
);
    localparam int POS_W = $clog2(ID_W + 1);
    localparam int IDX_W = $clog2(ID_W);
    localparam int CB_W  = $clog2(CMD_W);

    typedef struct packed {
        phase_e            ph;
        logic [CB_W-1:0]   cb;
        logic [POS_W-1:0]  pos;
        logic [POS_W-1:0]  ldisc;
        logic [POS_W-1:0]  ndisc;
        logic              rt;
        logic [ID_W-1:0]   rom;
        logic              last;
        logic              done;
        logic              nodev;
        logic              noresp;
    } eng_t;

    eng_t s_d, s_q;

    logic             want;
    logic             xfer;
    logic [IDX_W-1:0] bit_idx;
    logic             pick_dir, pick_zero, pick_dead;
    slot_op_e         op_sel;

    assign bit_idx = IDX_W'(s_q.pos - POS_W'(1));
    assign xfer    = slot_req & slot_done;
    assign want    = (s_q.ph != PH_IDLE);

    enum_slot_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .want   (want),
        .done_i (slot_done),
        .req_o  (slot_req)
    );

    enum_branch_pick #(.POS_W(POS_W)) u_pick (
        .bit_t     (s_q.rt),
        .bit_c     (slot_rbit),
        .pos       (s_q.pos),
        .last_fork (s_q.ldisc),
        .prev_bit  (s_q.rom[bit_idx]),
        .dir       (pick_dir),
        .zero_fork (pick_zero),
        .dead      (pick_dead)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph     = PH_PRES;
                    s_d.pos    = POS_W'(1);
                    s_d.ndisc  = '0;
                    s_d.cb     = '0;
                    s_d.nodev  = 1'b0;
                    s_d.noresp = 1'b0;
                    s_d.last   = 1'b0;
                    if (s_q.last) s_d.ldisc = '0;
                end
            end
            PH_PRES: begin
                if (xfer) begin
                    if (!slot_rbit) begin
                        s_d.ph    = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.nodev = 1'b1;
                        s_d.ldisc = '0;
                    end else begin
                        s_d.ph = PH_CMD;
                    end
                end
            end
            PH_CMD: begin
                if (xfer) begin
                    if (s_q.cb == CB_W'(CMD_W - 1)) s_d.ph = PH_RD_T;
                    else                            s_d.cb = s_q.cb + CB_W'(1);
                end
            end
            PH_RD_T: begin
                if (xfer) begin
                    s_d.rt = slot_rbit;
                    s_d.ph = PH_RD_C;
                end
            end
            PH_RD_C: begin
                if (xfer) begin
                    if (pick_dead) begin
                        s_d.ph     = PH_IDLE;
                        s_d.done   = 1'b1;
                        s_d.noresp = 1'b1;
                        s_d.ldisc  = '0;
                    end else begin
                        s_d.rom[bit_idx] = pick_dir;
                        if (pick_zero) s_d.ndisc = s_q.pos;
                        s_d.ph = PH_WR;
                    end
                end
            end
            PH_WR: begin
                if (xfer) begin
                    if (s_q.pos == POS_W'(ID_W)) begin
                        s_d.ph    = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.ldisc = s_q.ndisc;
                        s_d.last  = (s_q.ndisc == '0);
                    end else begin
                        s_d.pos = s_q.pos + POS_W'(1);
                        s_d.ph  = PH_RD_T;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.ph)
            PH_PRES:             op_sel = OP_RESET;
            PH_RD_T, PH_RD_C:    op_sel = OP_READ;
            default:             op_sel = OP_WRITE;
        endcase
        if (s_q.ph == PH_CMD)     slot_wbit = CMD_CODE[s_q.cb];
        else if (s_q.ph == PH_WR) slot_wbit = s_q.rom[bit_idx];
        else                      slot_wbit = 1'b0;
    end

    assign slot_op     = op_sel;
    assign busy        = want;
    assign pass_done   = s_q.done;
    assign rom_id      = s_q.rom;
    assign last_found  = s_q.last;
    assign no_device   = s_q.nodev;
    assign no_response = s_q.noresp;

    // R1: a pass opens with a line reset request
    p_first_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> slot_req && slot_op == 2'd0);

    // R1: start during a pass does not end or restart it
    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !slot_done |=> busy);

    // R7: the two error flags never appear together
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({no_device, no_response}));

    // R7: no slot is requested once a dead position ends the pass
    p_dead_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done && no_response |-> !slot_req);

    // R8: completion is reported only when the engine is idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> !busy);

    // R8: last_found only rises on a clean completion
    p_last_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last_found) |-> pass_done && !no_device && !no_response);

    // R8: result holds while idle
    p_rom_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(rom_id));

endmodule

// File: tb/test_bus_enum_master.sv
module test_bus_enum_master;

    localparam logic [1:0] OPC_RESET = 2'd0;
    localparam logic [1:0] OPC_WRITE = 2'd1;
    localparam logic [1:0] OPC_READ  = 2'd2;
    localparam logic [7:0] SEARCH_CMD = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        busy, pass_done, last_found, no_device, no_response;
    logic [63:0] rom_id;
    logic        slot_req, slot_wbit, slot_done, slot_rbit;
    logic [1:0]  slot_op;

    always #4 clk = ~clk;

    bus_enum_master i_bus_enum_master (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .pass_done(pass_done), .rom_id(rom_id), .last_found(last_found),
        .no_device(no_device), .no_response(no_response),
        .slot_req(slot_req), .slot_op(slot_op), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    int n_vec = 0;
    int n_bad = 0;

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // device population on the wired-AND line
    logic [63:0] devs [16];
    bit          act  [16];
    int          ndev = 0;
    int          drop_at = 0;

    // search bookkeeping of the bench
    int          sidx;
    int          m_ldisc = 0;
    int          m_ndisc = 0;
    bit          m_restart = 1'b1;
    logic [63:0] m_rom = '0;
    bit          m_rt, m_rc;
    int          m_end;   // 0 running, 1 no device, 2 no response, 3 complete

    function automatic bit line_and(int b, bit comp);
        bit r = 1'b1;
        for (int i = 0; i < ndev; i++)
            if (act[i]) r = r & (comp ? ~devs[i][b] : devs[i][b]);
        return r;
    endfunction

    task automatic do_slot(input logic [1:0] op, input logic w, output logic r);
        int k, ph, pos;
        bit exp, frk;
        r = 1'b0;
        if (m_end != 0) begin
            chk(1'b0, "R7 slot after end of pass", {62'd0, op}, 64'd0);
        end else if (sidx == 0) begin
            chk(op == OPC_RESET, "R1 first slot is reset", {62'd0, op}, {62'd0, OPC_RESET});
            for (int i = 0; i < 16; i++) act[i] = 1'b1;
            r = (ndev > 0);
            if (!r) m_end = 1;
        end else if (sidx <= 8) begin
            chk(op == OPC_WRITE && w == SEARCH_CMD[sidx-1], "R3 command bit",
                {61'd0, op, w}, {61'd0, OPC_WRITE, SEARCH_CMD[sidx-1]});
        end else begin
            k   = (sidx - 9) / 3;
            ph  = (sidx - 9) % 3;
            pos = k + 1;
            if (ph == 0) begin
                chk(op == OPC_READ, "R4 first read", {62'd0, op}, {62'd0, OPC_READ});
                r = (pos == drop_at) ? 1'b1 : line_and(k, 1'b0);
                m_rt = r;
            end else if (ph == 1) begin
                chk(op == OPC_READ, "R4 second read", {62'd0, op}, {62'd0, OPC_READ});
                r = (pos == drop_at) ? 1'b1 : line_and(k, 1'b1);
                m_rc = r;
                if (m_rt && m_rc) m_end = 2;
            end else begin
                chk(op == OPC_WRITE, "R4 branch write", {62'd0, op}, {62'd0, OPC_WRITE});
                frk = !m_rt && !m_rc;
                if (!frk)               exp = m_rt;
                else if (pos == m_ldisc) exp = 1'b1;
                else if (pos > m_ldisc)  exp = 1'b0;
                else                     exp = m_rom[k];
                chk(w == exp, frk ? "R6 fork branch" : "R5 plain branch",
                    {32'd0, 31'd0, w}, {63'd0, exp});
                m_rom[k] = exp;
                if (frk && !exp) m_ndisc = pos;
                for (int i = 0; i < ndev; i++)
                    if (devs[i][k] != w) act[i] = 1'b0;
                if (pos == 64) begin
                    m_end = 3;
                    m_ldisc = m_ndisc;
                end
            end
        end
        sidx++;
    endtask

    // slot layer responder plus per-clock handshake comparison
    initial begin
        logic       pr_req, pr_done, pr_w, rb;
        logic [1:0] pr_op;
        int         wcnt, lat;
        pr_req = 0; pr_done = 0; pr_w = 0; pr_op = 0;
        wcnt = 0; lat = 0;
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pr_req && !pr_done)
                    chk(slot_req && slot_op == pr_op && slot_wbit == pr_w, "R10 hold",
                        {60'd0, slot_req, slot_op, slot_wbit}, {60'd0, 1'b1, pr_op, pr_w});
                else if (pr_req && pr_done)
                    chk(!slot_req, "R10 gap", {63'd0, slot_req}, 64'd0);
            end
            pr_req = slot_req;
            pr_op  = slot_op;
            pr_w   = slot_wbit;
            if (slot_done) begin
                slot_done = 1'b0;
            end else if (slot_req && rst_n) begin
                if (wcnt < lat) wcnt++;
                else begin
                    do_slot(slot_op, slot_wbit, rb);
                    slot_rbit = rb;
                    slot_done = 1'b1;
                    wcnt = 0;
                    lat = (lat + 1) % 3;
                end
            end
            pr_done = slot_done;
        end
    end

    task automatic run_pass(input bit poke_mid, output logic [63:0] id);
        int guard;
        if (m_restart) m_ldisc = 0;
        m_restart = 1'b0;
        m_ndisc = 0;
        m_end = 0;
        sidx = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1 busy after start", {63'd0, busy}, 64'd1);
        if (poke_mid) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R1 start while busy ignored", {63'd0, busy}, 64'd1);
        end
        guard = 0;
        while (!pass_done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (m_end == 1) begin
            chk(no_device && !no_response, "R2 no-device flag", {62'd0, no_device, no_response}, 64'd2);
            chk(sidx == 1, "R2 single slot", sidx, 1);
        end else if (m_end == 2) begin
            chk(no_response && !no_device, "R7 no-response flag", {62'd0, no_device, no_response}, 64'd1);
        end else begin
            chk(m_end == 3, "R4 pass ran all positions", m_end, 3);
            chk(rom_id == m_rom, "R8 result", rom_id, m_rom);
            chk(!no_device && !no_response, "R8 flags clear", {62'd0, no_device, no_response}, 64'd0);
            chk(last_found == (m_ndisc == 0), "R8 last_found", {63'd0, last_found}, {63'd0, m_ndisc == 0});
        end
        id = rom_id;
        m_restart = (m_end != 3) || (m_ndisc == 0);
        @(negedge clk);
        chk(!pass_done, "R8 done is one cycle", {63'd0, pass_done}, 64'd0);
        repeat (4) begin
            @(negedge clk);
            chk(!slot_req && !busy, "R2 R7 quiet after pass", {62'd0, slot_req, busy}, 64'd0);
        end
        chk(rom_id == id, "R8 result held while idle", rom_id, id);
    endtask

    task automatic enumerate_all(input bit poke_first);
        logic [63:0] found [16];
        logic [63:0] id;
        int nf;
        bit hit;
        nf = 0;
        for (int p = 0; p < 2 * ndev + 2; p++) begin
            run_pass(poke_first && p == 0, id);
            found[nf] = id;
            nf++;
            if (last_found) break;
        end
        chk(nf == ndev, "R9 one pass per device", nf, ndev);
        for (int i = 0; i < nf; i++) begin
            hit = 1'b0;
            for (int j = 0; j < ndev; j++) if (devs[j] == found[i]) hit = 1'b1;
            for (int j = 0; j < i; j++) if (found[j] == found[i]) hit = 1'b0;
            chk(hit, "R9 distinct listed device", found[i], found[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] id;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !pass_done && !last_found && !no_device && !no_response && !slot_req,
            "R11 state in reset", {58'd0, busy, pass_done, last_found, no_device, no_response, slot_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !slot_req && !last_found, "R11 state after reset",
            {61'd0, busy, slot_req, last_found}, 64'd0);

        // empty line
        ndev = 0;
        run_pass(1'b0, id);

        // single device, found twice in a row
        ndev = 1;
        devs[0] = 64'h0123_4567_89AB_CDEF;
        run_pass(1'b0, id);
        chk(id == devs[0] && last_found, "R8 single device", id, devs[0]);
        run_pass(1'b0, id);
        chk(id == devs[0], "R9 restart after last", id, devs[0]);

        // forks at the first and at the last position
        ndev = 3;
        devs[0] = 64'h8000_0000_0000_0000;
        devs[1] = 64'h0000_0000_0000_0000;
        devs[2] = 64'h0000_0000_0000_0001;
        run_pass(1'b0, id);
        chk(id == 64'h0 && !last_found, "R6 fork at both ends, pass 1", id, 64'h0);
        run_pass(1'b0, id);
        chk(id == 64'h8000_0000_0000_0000 && !last_found, "R6 fork at last position, pass 2",
            id, 64'h8000_0000_0000_0000);
        run_pass(1'b0, id);
        chk(id == 64'h1 && last_found, "R9 final device, pass 3", id, 64'h1);
        run_pass(1'b0, id);
        chk(id == 64'h0, "R9 new enumeration", id, 64'h0);

        // every device vanishes at position 10
        ndev = 2;
        devs[0] = 64'h0000_00FF_0000_1234;
        devs[1] = 64'h0000_00FF_0000_1236;
        drop_at = 10;
        run_pass(1'b0, id);
        drop_at = 0;
        enumerate_all(1'b0);

        // larger population, with a stray start in the first pass
        ndev = 5;
        devs[0] = 64'hA5A5_0F0F_1234_5678;
        devs[1] = 64'hA5A5_0F0F_1234_5670;
        devs[2] = 64'h5A5A_F0F0_8765_4321;
        devs[3] = 64'hFFFF_FFFF_FFFF_FFFE;
        devs[4] = 64'h7FFF_FFFF_FFFF_FFFE;
        enumerate_all(1'b1);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule